// File: doc/BRIEF.md
# Call and Branch Sequencer

This block picks the next program counter for a small 8-bit controller core with a 16-bit program space. Each cycle the core may present one decoded control-flow operation on a strobe. The operation is either a jump, a call, a return, or a move of the indirect pointer register to or from the hardware return stack. The block checks the branch condition against the carry, overflow and zero flags and two event bits. It then picks the target: an immediate or the pointer register. It updates a shallow shift-register return stack and reports the next PC, any write to the pointer register, and a status-update pulse for interrupt returns.

An immediate target arrives bit-inverted in the instruction word, and the block uses its complement. Calls come in two kinds. A stack call saves the return address on the hardware stack. A short call saves it in the pointer register, so the callee can return through a pointer jump. Instruction fetch, decode and the status register itself stay outside the block.

The operation interface is a plain single-cycle strobe. The block accepts an operation on every cycle and applies no back-pressure. Every result comes out registered, together with a one-cycle valid pulse.

Top module: `branch_seq`

## Requirements
- R1: After reset `nxt_valid`, `ptr_wr_en` and `stat_exit` are 0, `pc_nxt` is 0, and every stack entry is 0, so a return issued straight after reset yields 0.
- R2: Conditional jumps (op codes 1 and 2) are taken according to `cond` as follows: 0 carry clear, 1 overflow clear, 2 zero clear, 3 always, 4 carry set, 5 overflow set, 6 zero set, 7 either bit of `evt` set.
- R3: For immediate-target operations (op codes 1, 3, 5) the target is the bitwise complement of `imm_n`.
- R4: A jump that is not taken, op code 0, and the unused op codes 11 to 15 give `pc + 1`, wrapping modulo 2^16, and leave the stack and the pointer register untouched.
- R5: A stack call (op 3 immediate, op 4 pointer) pushes `pc + 1` and jumps to the target. A return (op 7) jumps to the top entry and pops it.
- R6: A short call (op 5 immediate, op 6 pointer) pulses `ptr_wr_en` with `ptr_wr_data = pc + 1` and jumps to the target, leaving the stack unchanged. Op 6 jumps to the pointer value held before the write.
- R7: Pointer-target operations (op 2 jump, op 4 call) take their target from `ptr`.
- R8: Op 9 pushes `ptr` onto the stack. Op 10 writes the top stack entry to the pointer register through `ptr_wr_en`/`ptr_wr_data` and pops. Both give `pc + 1`.
- R9: A push moves every entry one place deeper and drops the deepest one. A pop moves every entry one place toward the top and leaves the deepest entry in place, so pops beyond the pushed depth keep returning that value.
- R10: Op 8 behaves like a return and also raises `stat_exit` for exactly the cycle in which its result is valid.
- R11: Every result appears on the outputs, with `nxt_valid` high, one clock after the strobe cycle. Without a strobe `nxt_valid`, `ptr_wr_en` and `stat_exit` stay 0 and the stack does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_kind | input | 4 | Operation code (0 none, 1 jump imm, 2 jump ptr, 3 call imm, 4 call ptr, 5 short call imm, 6 short call ptr, 7 return, 8 interrupt return, 9 push ptr, 10 pop ptr) |
| cond | input | 3 | Branch condition code |
| imm_n | input | 16 | Inverted immediate target |
| pc | input | 16 | Current program counter |
| ptr | input | 16 | Indirect pointer register value |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| evt | input | 2 | Event bits from the status register |
| nxt_valid | output | 1 | Result valid pulse |
| pc_nxt | output | 16 | Next program counter |
| ptr_wr_en | output | 1 | Pointer register write strobe |
| ptr_wr_data | output | 16 | Pointer register write data |
| stat_exit | output | 1 | Status-register update pulse for interrupt return |

## Verification
Every output of this block is due exactly one clock edge after the strobe cycle, because all of them come from a single register stage. Stack effects only become visible through a later return or pop, so they show up one edge after that later operation. Each bench task drives the inputs on a falling edge, holds the strobe for one cycle, and samples on the next falling edge. That is half a period after the edge that updates the results. Idle checks sample `nxt_valid` on falling edges with no strobe pending, then show that the stack is unchanged with a following return.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;
  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_JMP_IMM   = 4'd1,
    OP_JMP_PTR   = 4'd2,
    OP_CALL_IMM  = 4'd3,
    OP_CALL_PTR  = 4'd4,
    OP_SCALL_IMM = 4'd5,
    OP_SCALL_PTR = 4'd6,
    OP_RET       = 4'd7,
    OP_RETI      = 4'd8,
    OP_PUSH_PTR  = 4'd9,
    OP_POP_PTR   = 4'd10
  } op_kind_e;

  typedef enum logic [2:0] {
    CC_NC  = 3'd0,
    CC_NV  = 3'd1,
    CC_NZ  = 3'd2,
    CC_AL  = 3'd3,
    CC_C   = 3'd4,
    CC_V   = 3'd5,
    CC_Z   = 3'd6,
    CC_EVT = 3'd7
  } cond_e;
endpackage

// File: rtl/branch_cond.sv
module branch_cond
  import branch_seq_pkg::*;
#(
  parameter int EVT_W = 2
) (
  input  logic [2:0]       cond,
  input  logic             flag_c,
  input  logic             flag_v,
  input  logic             flag_z,
  input  logic [EVT_W-1:0] evt,
  output logic             taken
);
  always_comb begin
    unique case (cond_e'(cond))
      CC_NC:   taken = ~flag_c;
      CC_NV:   taken = ~flag_v;
      CC_NZ:   taken = ~flag_z;
      CC_AL:   taken = 1'b1;
      CC_C:    taken = flag_c;
      CC_V:    taken = flag_v;
      CC_Z:    taken = flag_z;
      default: taken = |evt;
    endcase
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top
);
  localparam int LAST = DEPTH - 1;

  logic [W-1:0] ent     [DEPTH];
  logic [W-1:0] ent_nxt [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_head
      assign ent_nxt[i] = push ? din : (pop ? ent[1] : ent[0]);
    end else if (i == LAST) begin : g_tail
      assign ent_nxt[i] = push ? ent[i-1] : ent[i];
    end else begin : g_mid
      assign ent_nxt[i] = push ? ent[i-1] : (pop ? ent[i+1] : ent[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) ent[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) ent[k] <= ent_nxt[k];
    end
  end

  assign top = ent[0];

  // R5
  push_lands_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top == $past(din));

  // R9
  pop_lifts_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> top == $past(ent[1]));

  // R9
  pop_keeps_deepest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> ent[LAST] == $past(ent[LAST]));

  // R11
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !push) |=> $stable(top));
endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import branch_seq_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  parameter int EVT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_kind,
  input  logic [2:0]       cond,
  input  logic [PC_W-1:0]  imm_n,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  ptr,
  input  logic             flag_c,
  input  logic             flag_v,
  input  logic             flag_z,
  input  logic [EVT_W-1:0] evt,
  output logic             nxt_valid,
  output logic [PC_W-1:0]  pc_nxt,
  output logic             ptr_wr_en,
  output logic [PC_W-1:0]  ptr_wr_data,
  output logic             stat_exit
);
  logic            taken;
  logic [PC_W-1:0] tgt_imm, pc_inc, top;
  logic [PC_W-1:0] nxt_d, pwd_d, sdin;
  logic            pwe_d, sx_d, push_d, pop_d;

  branch_cond #(.EVT_W(EVT_W)) u_cond (
    .cond(cond), .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z),
    .evt(evt), .taken(taken)
  );

  ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_d & op_valid),
    .pop(pop_d & op_valid), .din(sdin), .top(top)
  );

  assign tgt_imm = ~imm_n;
  assign pc_inc  = pc + 1'b1;

  always_comb begin
    nxt_d  = pc_inc;
    pwe_d  = 1'b0;
    pwd_d  = '0;
    sx_d   = 1'b0;
    push_d = 1'b0;
    pop_d  = 1'b0;
    sdin   = pc_inc;
    case (op_kind_e'(op_kind))
      OP_JMP_IMM:   nxt_d = taken ? tgt_imm : pc_inc;
      OP_JMP_PTR:   nxt_d = taken ? ptr : pc_inc;
      OP_CALL_IMM:  begin nxt_d = tgt_imm; push_d = 1'b1; end
      OP_CALL_PTR:  begin nxt_d = ptr;     push_d = 1'b1; end
      OP_SCALL_IMM: begin nxt_d = tgt_imm; pwe_d = 1'b1; pwd_d = pc_inc; end
      OP_SCALL_PTR: begin nxt_d = ptr;     pwe_d = 1'b1; pwd_d = pc_inc; end
      OP_RET:       begin nxt_d = top;     pop_d = 1'b1; end
      OP_RETI:      begin nxt_d = top;     pop_d = 1'b1; sx_d = 1'b1; end
      OP_PUSH_PTR:  begin push_d = 1'b1;   sdin = ptr; end
      OP_POP_PTR:   begin pop_d = 1'b1;    pwe_d = 1'b1; pwd_d = top; end
      default:      nxt_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_valid   <= 1'b0;
      pc_nxt      <= '0;
      ptr_wr_en   <= 1'b0;
      ptr_wr_data <= '0;
      stat_exit   <= 1'b0;
    end else begin
      nxt_valid <= op_valid;
      ptr_wr_en <= op_valid & pwe_d;
      stat_exit <= op_valid & sx_d;
      if (op_valid) begin
        pc_nxt      <= nxt_d;
        ptr_wr_data <= pwd_d;
      end
    end
  end

  // R11
  result_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> nxt_valid);

  // R11
  no_write_without_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |-> nxt_valid);

  // R10
  exit_only_for_reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_exit |-> (nxt_valid && $past(op_kind) == OP_RETI));

  // R3
  always_jump_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_valid && $past(op_kind) == OP_JMP_IMM && $past(cond) == 3'd3)
      |-> pc_nxt == ~$past(imm_n));

  // R4
  plain_op_increments_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_valid && $past(op_kind) == OP_NONE) |-> pc_nxt == $past(pc) + 1'b1);
endmodule

// File: tb/branch_seq_bench.sv
`timescale 1ns/1ps
module branch_seq_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_kind = '0;
  logic [2:0]  cond = '0;
  logic [15:0] imm_n = '0, pc = '0, ptr = '0;
  logic        flag_c = 1'b0, flag_v = 1'b0, flag_z = 1'b0;
  logic [1:0]  evt = '0;
  logic        nxt_valid, ptr_wr_en, stat_exit;
  logic [15:0] pc_nxt, ptr_wr_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  branch_seq u_branch_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .cond(cond), .imm_n(imm_n), .pc(pc), .ptr(ptr), .flag_c(flag_c),
    .flag_v(flag_v), .flag_z(flag_z), .evt(evt), .nxt_valid(nxt_valid),
    .pc_nxt(pc_nxt), .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
    .stat_exit(stat_exit)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one strobe on a falling edge; results are sampled on the next falling edge.
  task automatic issue(input logic [3:0] k, input logic [2:0] c,
                       input logic [15:0] tgt, input logic [15:0] p,
                       input logic [15:0] pr);
    @(negedge clk);
    op_kind = k; cond = c; imm_n = ~tgt; pc = p; ptr = pr; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", {15'd0, nxt_valid}, 16'd0);
    chk("R1 pc", pc_nxt, 16'd0);
    chk("R1 ptrwe", {15'd0, ptr_wr_en}, 16'd0);
    chk("R1 exit", {15'd0, stat_exit}, 16'd0);
    issue(4'd7, 3'd0, 16'h0, 16'h0040, 16'h0);
    chk("R1 empty stack top", pc_nxt, 16'h0000);
  endtask

  task automatic t_cond;
    for (int f = 0; f < 8; f++) begin
      for (int c = 0; c < 8; c++) begin
        bit tk;
        flag_c = f[0]; flag_v = f[1]; flag_z = f[2];
        evt = (f == 3) ? 2'b01 : ((f == 5) ? 2'b10 : 2'b00);
        case (c)
          0: tk = !f[0];
          1: tk = !f[1];
          2: tk = !f[2];
          3: tk = 1'b1;
          4: tk = f[0];
          5: tk = f[1];
          6: tk = f[2];
          default: tk = (f == 3) || (f == 5);
        endcase
        issue(4'd1, 3'(c), 16'hA5C3, 16'h1200, 16'h0);
        chk("R2 cond", pc_nxt, tk ? 16'hA5C3 : 16'h1201);
      end
    end
    flag_c = 0; flag_v = 0; flag_z = 0; evt = 0;
  endtask

  task automatic t_imm;
    issue(4'd1, 3'd3, 16'h0000, 16'h0010, 16'h0);
    chk("R3 target 0000", pc_nxt, 16'h0000);
    issue(4'd1, 3'd3, 16'hFFFF, 16'h0010, 16'h0);
    chk("R3 target FFFF", pc_nxt, 16'hFFFF);
  endtask

  task automatic t_plus1;
    issue(4'd0, 3'd3, 16'h4444, 16'h0123, 16'h0);
    chk("R4 none", pc_nxt, 16'h0124);
    chk("R4 none ptrwe", {15'd0, ptr_wr_en}, 16'd0);
    issue(4'd0, 3'd3, 16'h4444, 16'hFFFF, 16'h0);
    chk("R4 wrap", pc_nxt, 16'h0000);
    issue(4'd13, 3'd3, 16'h4444, 16'h0200, 16'h0);
    chk("R4 unused code", pc_nxt, 16'h0201);
    flag_z = 1'b1;
    issue(4'd2, 3'd2, 16'h0, 16'h0300, 16'h7777);
    chk("R4 ptr not taken", pc_nxt, 16'h0301);
    flag_z = 1'b0;
    issue(4'd7, 3'd0, 16'h0, 16'h0, 16'h0);
    chk("R4 stack untouched", pc_nxt, 16'h0000);
  endtask

  task automatic t_call_ret;
    issue(4'd3, 3'd0, 16'h2000, 16'h0050, 16'h0);
    chk("R5 call target", pc_nxt, 16'h2000);
    issue(4'd4, 3'd0, 16'h0, 16'h2005, 16'h3000);
    chk("R7 call via ptr", pc_nxt, 16'h3000);
    issue(4'd7, 3'd0, 16'h0, 16'h3003, 16'h0);
    chk("R5 ret inner", pc_nxt, 16'h2006);
    issue(4'd7, 3'd0, 16'h0, 16'h2010, 16'h0);
    chk("R5 ret outer", pc_nxt, 16'h0051);
  endtask

  task automatic t_short;
    issue(4'd5, 3'd0, 16'h4000, 16'h0080, 16'h0);
    chk("R6 target", pc_nxt, 16'h4000);
    chk("R6 we", {15'd0, ptr_wr_en}, 16'd1);
    chk("R6 data", ptr_wr_data, 16'h0081);
    issue(4'd6, 3'd0, 16'h0, 16'h4002, 16'h0081);
    chk("R6 R7 ptr target", pc_nxt, 16'h0081);
    chk("R6 ptr data", ptr_wr_data, 16'h4003);
    issue(4'd7, 3'd0, 16'h0, 16'h0, 16'h0);
    chk("R6 stack unchanged", pc_nxt, 16'h0000);
    issue(4'd2, 3'd3, 16'h0, 16'h0090, 16'hBEEF);
    chk("R7 jump via ptr", pc_nxt, 16'hBEEF);
  endtask

  task automatic t_push_pop;
    issue(4'd9, 3'd0, 16'h0, 16'h0100, 16'hCAFE);
    chk("R8 push pc", pc_nxt, 16'h0101);
    chk("R8 push no ptrwe", {15'd0, ptr_wr_en}, 16'd0);
    issue(4'd10, 3'd0, 16'h0, 16'h0101, 16'h0);
    chk("R8 pop pc", pc_nxt, 16'h0102);
    chk("R8 pop we", {15'd0, ptr_wr_en}, 16'd1);
    chk("R8 pop data", ptr_wr_data, 16'hCAFE);
  endtask

  task automatic t_overflow;
    for (int k = 0; k <= DEPTH; k++)
      issue(4'd3, 3'd0, 16'h5000, 16'(16'h0100 + k), 16'h0);
    for (int k = 0; k < DEPTH; k++) begin
      issue(4'd7, 3'd0, 16'h0, 16'h5000, 16'h0);
      chk("R9 pop order", pc_nxt, 16'(16'h0101 + DEPTH - k));
    end
    issue(4'd7, 3'd0, 16'h0, 16'h5000, 16'h0);
    chk("R9 deepest kept", pc_nxt, 16'h0102);
  endtask

  task automatic t_reti;
    issue(4'd3, 3'd0, 16'h6000, 16'h0700, 16'h0);
    chk("R10 exit low on call", {15'd0, stat_exit}, 16'd0);
    issue(4'd8, 3'd0, 16'h0, 16'h6004, 16'h0);
    chk("R10 reti pc", pc_nxt, 16'h0701);
    chk("R10 exit high", {15'd0, stat_exit}, 16'd1);
    @(negedge clk);
    chk("R10 exit one cycle", {15'd0, stat_exit}, 16'd0);
  endtask

  task automatic t_idle;
    issue(4'd3, 3'd0, 16'h7000, 16'h0A00, 16'h0);
    chk("R11 valid one cycle after", {15'd0, nxt_valid}, 16'd1);
    op_kind = 4'd9; ptr = 16'h1111;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 no valid idle", {15'd0, nxt_valid}, 16'd0);
      chk("R11 no ptrwe idle", {15'd0, ptr_wr_en}, 16'd0);
    end
    issue(4'd7, 3'd0, 16'h0, 16'h7000, 16'h0);
    chk("R11 stack unchanged idle", pc_nxt, 16'h0A01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_cond;
    t_imm;
    t_plus1;
    t_call_ret;
    t_short;
    t_push_pop;
    t_overflow;
    t_reti;
    t_idle;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule